// File: doc/BRIEF.md
# Posted Register Access Engine for Power-Gated Domains

This block lets a host reach registers that sit inside power-gated domains without holding those domains awake between accesses. The host sees two 32-bit words on a small register interface: a data word and a control word. It loads the target offset, the direction and the domain choice into the control word, together with a start bit. The engine then raises a wake request towards the selected domain, or towards all of them. It waits for the acknowledges, performs one 32-bit read or write on a simple internal register port, releases the request and clears the start bit.

For a write, the host first places the value in the data word. For a read, the fetched value lands in the data word, and it is valid once the start bit reads back as zero. If the acknowledges do not all arrive within a cycle limit given on an input port, the command is abandoned. A sticky timeout flag records the event, and software clears that flag explicitly.

Top module: `dra_engine`

## Requirements
- R1: The data word sits at host offset 0xF00. While the engine is idle, a host write to it stores the value, and a read returns it. Host reads are combinational on `host_addr`, and any offset other than 0xF00 or 0xF04 reads as zero.
- R2: The control word sits at host offset 0xF04 and has this layout:
  - bit 31: busy/start (GO)
  - bit 30: sticky timeout flag
  - bits 29:28: domain select
  - bit 24: operation (0 = write, 1 = read)
  - bits 23:0: target offset

  An idle write stores the domain, operation and offset fields whatever bit 31 holds. Bits 27:25 are ignored on write and read as zero.
- R3: An idle write to the control word with bit 31 set starts a command. Bit 31 then reads 1 until that command completes. While it is 0, no wake request and no target access is driven.
- R4: Domain codes 0, 1 and 2 drive `wake_req` bit 0, bit 1 and bit 2 respectively, and code 3 drives all three bits. The request is held, with no access performed, until every requested acknowledge is high.
- R5: A write command produces one target cycle with `tgt_en`=1 and `tgt_we`=1, carrying the stored offset on `tgt_addr` and the data word on `tgt_wdata`.
- R6: A read command produces one target cycle with `tgt_en`=1 and `tgt_we`=0. The `tgt_rdata` value present in the cycle after that access is stored into the data word.
- R7: The wake request is released in the cycle after the access, and bit 31 clears one cycle later. When the acknowledges are already high, bit 31 reads 1 for exactly 3 cycles.
- R8: While bit 31 is set, host writes to both the data word and the control word are ignored.
- R9: If the acknowledges are not all high within `wake_limit`+1 waiting cycles, the command is abandoned. In that case no target access occurs, the data word is unchanged, bit 30 is set, and bit 31 clears after `wake_limit`+2 cycles.
- R10: The timeout flag stays set across later successful commands. An idle control write with bit 30 set clears it.
- R11: After reset, both host words read zero and `wake_req`, `tgt_en` and `tgt_we` are low.
- R12: Each started command produces at most one `tgt_en` cycle, and `tgt_en` is never high on two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_we | input | 1 | Host write strobe |
| host_addr | input | 12 | Host word offset |
| host_wdata | input | 32 | Host write data |
| host_rdata | output | 32 | Host read data, combinational on host_addr |
| wake_limit | input | 16 | Wait cycles allowed before a command is abandoned |
| wake_req | output | 3 | Per-domain wake request |
| wake_ack | input | 3 | Per-domain wake acknowledge |
| tgt_en | output | 1 | Internal register port access strobe |
| tgt_we | output | 1 | Internal register port write enable |
| tgt_addr | output | 24 | Internal register port offset |
| tgt_wdata | output | 32 | Internal register port write data |
| tgt_rdata | input | 32 | Internal register port read data, valid the cycle after the strobe |

## Verification
Commands are issued under four acknowledge patterns:
- delayed per-domain acknowledges, which show that the request is held until the acknowledge arrives;
- all domains selected with staggered responders, which separates waiting for one acknowledge from waiting for all of them;
- acknowledges already high, which pins the minimum busy length;
- one responder switched off, which drives the abort path.

Host writes landing in the middle of a held command show whether they leak into the stored fields. A write followed by a read to the same offset shows that data really travels in both directions rather than being echoed back. A further successful command after an abort, followed by an explicit clear, shows that the timeout flag is sticky and that it can be cleared.

// File: rtl/dra_pkg.sv
package dra_pkg;

   typedef enum logic [1:0] {
      PH_IDLE = 2'd0,
      PH_WAIT = 2'd1,
      PH_XFER = 2'd2,
      PH_DONE = 2'd3
   } dra_phase_e;

   localparam logic OP_WR = 1'b0;
   localparam logic OP_RD = 1'b1;

endpackage

// File: rtl/dra_dom_decode.sv
module dra_dom_decode #(
   parameter int NUM_DOM = 3,
   parameter int SEL_W   = 2
) (
   input  logic [SEL_W-1:0]   sel,
   output logic [NUM_DOM-1:0] mask
);
   localparam logic [SEL_W-1:0] ALL_CODE = SEL_W'(NUM_DOM);

   for (genvar i = 0; i < NUM_DOM; i++) begin : g_dom
      assign mask[i] = (sel == SEL_W'(i)) || (sel == ALL_CODE);
   end
endmodule

// File: rtl/dra_wake_timer.sv
module dra_wake_timer #(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic [CNT_W-1:0] limit,
   output logic             expired
);
   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt_q <= '0;
      else if (!run)
         cnt_q <= '0;
      else
         cnt_q <= cnt_q + 1'b1;
   end

   assign expired = run && (cnt_q == limit);
endmodule

// File: rtl/dra_host_regs.sv
module dra_host_regs #(
   parameter int               ADDR_W    = 12,
   parameter int               DATA_W    = 32,
   parameter int               OFS_W     = 24,
   parameter int               SEL_W     = 2,
   parameter logic [ADDR_W-1:0] DATA_ADDR = 12'hF00,
   parameter logic [ADDR_W-1:0] CTRL_ADDR = 12'hF04,
   parameter int               GO_BIT    = 31,
   parameter int               FLAG_BIT  = 30,
   parameter int               SEL_LSB   = 28,
   parameter int               OP_BIT    = 24
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              host_we,
   input  logic [ADDR_W-1:0] host_addr,
   input  logic [DATA_W-1:0] host_wdata,
   output logic [DATA_W-1:0] host_rdata,
   input  logic              busy,
   input  logic              cap_en,
   input  logic [DATA_W-1:0] cap_data,
   input  logic              flag_set,
   output logic [DATA_W-1:0] data_q,
   output logic [OFS_W-1:0]  ofs_q,
   output logic              op_q,
   output logic [SEL_W-1:0]  sel_q,
   output logic              flag_q,
   output logic              start
);
   logic              data_hit;
   logic              ctrl_hit;
   logic [DATA_W-1:0] ctrl_view;

   assign data_hit = host_we && (host_addr == DATA_ADDR) && !busy;
   assign ctrl_hit = host_we && (host_addr == CTRL_ADDR) && !busy;
   assign start    = ctrl_hit && host_wdata[GO_BIT];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         data_q <= '0;
      end else if (cap_en) begin
         data_q <= cap_data;
      end else if (data_hit) begin
         data_q <= host_wdata;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ofs_q <= '0;
         op_q  <= 1'b0;
         sel_q <= '0;
      end else if (ctrl_hit) begin
         ofs_q <= host_wdata[OFS_W-1:0];
         op_q  <= host_wdata[OP_BIT];
         sel_q <= host_wdata[SEL_LSB +: SEL_W];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         flag_q <= 1'b0;
      else if (flag_set)
         flag_q <= 1'b1;
      else if (ctrl_hit && host_wdata[FLAG_BIT])
         flag_q <= 1'b0;
   end

   always_comb begin
      ctrl_view                     = '0;
      ctrl_view[GO_BIT]             = busy;
      ctrl_view[FLAG_BIT]           = flag_q;
      ctrl_view[SEL_LSB +: SEL_W]   = sel_q;
      ctrl_view[OP_BIT]             = op_q;
      ctrl_view[OFS_W-1:0]          = ofs_q;
   end

   always_comb begin
      if (host_addr == DATA_ADDR)
         host_rdata = data_q;
      else if (host_addr == CTRL_ADDR)
         host_rdata = ctrl_view;
      else
         host_rdata = '0;
   end
endmodule

// File: rtl/dra_engine.sv
module dra_engine #(
   parameter int               ADDR_W    = 12,
   parameter int               DATA_W    = 32,
   parameter int               OFS_W     = 24,
   parameter int               NUM_DOM   = 3,
   parameter int               CNT_W     = 16,
   parameter logic [ADDR_W-1:0] DATA_ADDR = 12'hF00,
   parameter logic [ADDR_W-1:0] CTRL_ADDR = 12'hF04
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               host_we,
   input  logic [ADDR_W-1:0]  host_addr,
   input  logic [DATA_W-1:0]  host_wdata,
   output logic [DATA_W-1:0]  host_rdata,
   input  logic [CNT_W-1:0]   wake_limit,
   output logic [NUM_DOM-1:0] wake_req,
   input  logic [NUM_DOM-1:0] wake_ack,
   output logic               tgt_en,
   output logic               tgt_we,
   output logic [OFS_W-1:0]   tgt_addr,
   output logic [DATA_W-1:0]  tgt_wdata,
   input  logic [DATA_W-1:0]  tgt_rdata
);
   import dra_pkg::*;

   localparam int SEL_W    = $clog2(NUM_DOM + 1);
   localparam int GO_BIT   = DATA_W - 1;
   localparam int FLAG_BIT = DATA_W - 2;
   localparam int SEL_LSB  = DATA_W - 4;
   localparam int OP_BIT   = DATA_W - 8;

   if (SEL_LSB + SEL_W > FLAG_BIT) begin : g_bad_sel
      $error("domain select field overlaps the timeout flag");
   end
   if (OFS_W > OP_BIT) begin : g_bad_ofs
      $error("offset field overlaps the operation bit");
   end
   if (DATA_W < 16) begin : g_bad_width
      $error("data word too narrow for the control layout");
   end

   dra_phase_e         phase_q, phase_d;
   logic               xfer_q;
   logic               busy;
   logic               start;
   logic               tmo_flag;
   logic               flag_set;
   logic               cap_en;
   logic               acks_ok;
   logic               expired;
   logic [DATA_W-1:0]  data_q;
   logic [OFS_W-1:0]   ofs_q;
   logic               op_q;
   logic [SEL_W-1:0]   sel_q;
   logic [NUM_DOM-1:0] dom_mask;

   assign busy    = (phase_q != PH_IDLE);
   assign acks_ok = ((wake_ack & dom_mask) == dom_mask);

   dra_host_regs #(
      .ADDR_W   (ADDR_W),
      .DATA_W   (DATA_W),
      .OFS_W    (OFS_W),
      .SEL_W    (SEL_W),
      .DATA_ADDR(DATA_ADDR),
      .CTRL_ADDR(CTRL_ADDR),
      .GO_BIT   (GO_BIT),
      .FLAG_BIT (FLAG_BIT),
      .SEL_LSB  (SEL_LSB),
      .OP_BIT   (OP_BIT)
   ) u_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .host_we   (host_we),
      .host_addr (host_addr),
      .host_wdata(host_wdata),
      .host_rdata(host_rdata),
      .busy      (busy),
      .cap_en    (cap_en),
      .cap_data  (tgt_rdata),
      .flag_set  (flag_set),
      .data_q    (data_q),
      .ofs_q     (ofs_q),
      .op_q      (op_q),
      .sel_q     (sel_q),
      .flag_q    (tmo_flag),
      .start     (start)
   );

   dra_dom_decode #(
      .NUM_DOM(NUM_DOM),
      .SEL_W  (SEL_W)
   ) u_dec (
      .sel (sel_q),
      .mask(dom_mask)
   );

   dra_wake_timer #(
      .CNT_W(CNT_W)
   ) u_timer (
      .clk    (clk),
      .rst_n  (rst_n),
      .run    (phase_q == PH_WAIT),
      .limit  (wake_limit),
      .expired(expired)
   );

   always_comb begin
      phase_d  = phase_q;
      flag_set = 1'b0;
      unique case (phase_q)
         PH_IDLE: if (start) phase_d = PH_WAIT;
         PH_WAIT: begin
            if (acks_ok) begin
               phase_d = PH_XFER;
            end else if (expired) begin
               phase_d  = PH_DONE;
               flag_set = 1'b1;
            end
         end
         PH_XFER: phase_d = PH_DONE;
         PH_DONE: phase_d = PH_IDLE;
         default: phase_d = PH_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase_q <= PH_IDLE;
         xfer_q  <= 1'b0;
      end else begin
         phase_q <= phase_d;
         xfer_q  <= (phase_q == PH_XFER);
      end
   end

   assign cap_en    = (phase_q == PH_DONE) && xfer_q && (op_q == OP_RD);
   assign wake_req  = ((phase_q == PH_WAIT) || (phase_q == PH_XFER)) ? dom_mask : '0;
   assign tgt_en    = (phase_q == PH_XFER);
   assign tgt_we    = tgt_en && (op_q == OP_WR);
   assign tgt_addr  = ofs_q;
   assign tgt_wdata = data_q;
endmodule

// File: rtl/dra_engine_chk.sv
module dra_engine_chk #(
   parameter int NUM_DOM = 3
) (
   input logic               clk,
   input logic               rst_n,
   input logic               busy,
   input logic               tmo_flag,
   input logic [NUM_DOM-1:0] wake_req,
   input logic [NUM_DOM-1:0] wake_ack,
   input logic               tgt_en
);
   p_idle_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> ((wake_req == '0) && !tgt_en));

   p_acked_access_r4: assert property (@(posedge clk) disable iff (!rst_n)
      tgt_en |-> ((wake_req != '0) && (($past(wake_ack) & wake_req) == wake_req)));

   p_req_steady_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && (wake_req != '0)) |=> ((wake_req == '0) || $stable(wake_req)));

   p_release_first_r7: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> ($past(wake_req) == '0));

   p_abort_clean_r9: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(tmo_flag) |-> (!tgt_en && !$past(tgt_en)));

   p_single_beat_r12: assert property (@(posedge clk) disable iff (!rst_n)
      tgt_en |=> !tgt_en);
endmodule

bind dra_engine dra_engine_chk #(.NUM_DOM(NUM_DOM)) u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .busy    (busy),
   .tmo_flag(tmo_flag),
   .wake_req(wake_req),
   .wake_ack(wake_ack),
   .tgt_en  (tgt_en)
);

// File: tb/dra_engine_tb.sv
`timescale 1ns/1ps
module dra_engine_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        host_we = 1'b0;
   logic [11:0] host_addr = 12'hF04;
   logic [31:0] host_wdata = '0;
   logic [31:0] host_rdata;
   logic [15:0] wake_limit = 16'd40;
   logic [2:0]  wake_req;
   logic [2:0]  wake_ack;
   logic        tgt_en, tgt_we;
   logic [23:0] tgt_addr;
   logic [31:0] tgt_wdata;
   logic [31:0] tgt_rdata = '0;

   int checks = 0;
   int errors = 0;
   int en_count = 0;

   always #2.5 clk = ~clk;

   dra_engine u_dut (
      .clk(clk), .rst_n(rst_n), .host_we(host_we), .host_addr(host_addr),
      .host_wdata(host_wdata), .host_rdata(host_rdata), .wake_limit(wake_limit),
      .wake_req(wake_req), .wake_ack(wake_ack), .tgt_en(tgt_en), .tgt_we(tgt_we),
      .tgt_addr(tgt_addr), .tgt_wdata(tgt_wdata), .tgt_rdata(tgt_rdata)
   );

   task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   // ---------------- target register file ----------------
   logic [31:0] mem [int];
   always @(posedge clk) begin
      if (tgt_en) begin
         en_count <= en_count + 1;
         if (tgt_we) mem[int'(tgt_addr)] = tgt_wdata;
         else if (mem.exists(int'(tgt_addr))) tgt_rdata <= mem[int'(tgt_addr)];
         else tgt_rdata <= 32'hC0DE0000 | {8'h0, tgt_addr};
      end
   end

   // ---------------- acknowledge responders ----------------
   logic [2:0] ack_auto = 3'b111;
   logic [2:0] ack_force = 3'b000;
   logic [2:0] hs = 3'b000;
   int         ack_delay = 2;
   int         ac [3];
   assign wake_ack = hs | ack_force;

   always @(posedge clk) begin
      for (int i = 0; i < 3; i++) begin
         if (!rst_n || !wake_req[i]) begin
            hs[i] <= 1'b0;
            ac[i] = 0;
         end else if (ack_auto[i]) begin
            if (ac[i] >= ack_delay + i) hs[i] <= 1'b1;
            else ac[i]++;
         end
      end
   end

   // ---------------- behavioural reference model ----------------
   int          m_ph;
   bit          m_tmo, m_op, m_did;
   logic [1:0]  m_dom;
   logic [23:0] m_off;
   logic [31:0] m_data;
   int          m_cnt;

   function automatic logic [2:0] dmask(logic [1:0] d);
      return (d == 2'd3) ? 3'b111 : (3'b001 << d);
   endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         m_ph = 0; m_tmo = 0; m_op = 0; m_did = 0;
         m_dom = '0; m_off = '0; m_data = '0; m_cnt = 0;
      end else begin
         case (m_ph)
            0: begin
               if (host_we && host_addr == 12'hF00) m_data = host_wdata;
               if (host_we && host_addr == 12'hF04) begin
                  m_off = host_wdata[23:0];
                  m_op  = host_wdata[24];
                  m_dom = host_wdata[29:28];
                  if (host_wdata[30]) m_tmo = 0;
                  if (host_wdata[31]) begin m_ph = 1; m_cnt = 0; m_did = 0; end
               end
            end
            1: begin
               if ((wake_ack & dmask(m_dom)) == dmask(m_dom)) m_ph = 2;
               else if (m_cnt == int'(wake_limit)) begin m_tmo = 1; m_ph = 3; end
               else m_cnt++;
            end
            2: begin m_did = 1; m_ph = 3; end
            default: begin
               if (m_did && m_op) m_data = tgt_rdata;
               m_ph = 0;
            end
         endcase
      end
   end

   always @(negedge clk) begin
      if (rst_n) begin
         logic [31:0] exp_rd;
         bit          exp_en;
         exp_en = (m_ph == 2);
         if (host_addr == 12'hF00) exp_rd = m_data;
         else if (host_addr == 12'hF04)
            exp_rd = {(m_ph != 0), m_tmo, m_dom, 3'b000, m_op, m_off};
         else exp_rd = '0;
         chk((host_addr == 12'hF04) ? "R2" : "R1", "host_rdata", host_rdata, exp_rd);
         chk("R4", "wake_req", {29'd0, wake_req},
             {29'd0, ((m_ph == 1) || (m_ph == 2)) ? dmask(m_dom) : 3'b000});
         chk("R12", "tgt_en", {31'd0, tgt_en}, {31'd0, exp_en});
         if (exp_en) begin
            chk("R5", "tgt_we", {31'd0, tgt_we}, {31'd0, !m_op});
            chk("R5", "tgt_addr", {8'd0, tgt_addr}, {8'd0, m_off});
            if (!m_op) chk("R5", "tgt_wdata", tgt_wdata, m_data);
         end
      end
   end

   // ---------------- host tasks ----------------
   task automatic hw(logic [11:0] a, logic [31:0] d);
      @(posedge clk); #1;
      host_we = 1'b1; host_addr = a; host_wdata = d;
      @(posedge clk); #1;
      host_we = 1'b0; host_addr = 12'hF04;
   endtask

   task automatic rd(logic [11:0] a, output logic [31:0] d);
      @(posedge clk); #1;
      host_addr = a;
      @(negedge clk);
      d = host_rdata;
   endtask

   task automatic wait_idle(output int go_cycles);
      go_cycles = 0;
      host_addr = 12'hF04;
      for (int k = 0; k < 2000; k++) begin
         @(negedge clk);
         if (host_rdata[31]) go_cycles++;
         else break;
      end
   endtask

   localparam logic [31:0] GO = 32'h8000_0000;
   localparam logic [31:0] RD = 32'h0100_0000;

   function automatic logic [31:0] dsel(int d);
      return 32'(d) << 28;
   endfunction

   initial begin
      logic [31:0] v;
      int n, e0;
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      @(negedge clk);
      chk("R11", "wake_req after reset", {29'd0, wake_req}, 32'd0);
      chk("R11", "tgt_en after reset", {31'd0, tgt_en}, 32'd0);
      chk("R11", "tgt_we after reset", {31'd0, tgt_we}, 32'd0);
      rd(12'hF00, v); chk("R11", "data word after reset", v, 32'd0);
      rd(12'hF04, v); chk("R11", "control word after reset", v, 32'd0);

      hw(12'hF00, 32'hDEADBEEF);
      rd(12'hF00, v); chk("R1", "data readback", v, 32'hDEADBEEF);
      hw(12'h100, 32'h12345678);
      rd(12'h100, v); chk("R1", "unmapped read", v, 32'd0);

      hw(12'hF04, 32'h2F00_0123);
      rd(12'hF04, v); chk("R2", "control layout", v, 32'h2100_0123);

      // write to blitter with delayed ack
      hw(12'hF00, 32'h1111_2222);
      e0 = en_count;
      hw(12'hF04, GO | dsel(0) | 32'h40);
      @(negedge clk);
      chk("R4", "blitter request", {29'd0, wake_req}, 32'd1);
      chk("R3", "GO busy", {31'd0, host_rdata[31]}, 32'd1);
      wait_idle(n);
      chk("R12", "one access per command", 32'(en_count - e0), 32'd1);
      chk("R5", "target stored value", mem[32'h40], 32'h1111_2222);

      // read back through render
      hw(12'hF00, 32'h0);
      hw(12'hF04, GO | RD | dsel(1) | 32'h40);
      wait_idle(n);
      rd(12'hF00, v); chk("R6", "read result", v, 32'h1111_2222);

      // all domains, staggered responders
      ack_delay = 4;
      hw(12'hF00, 32'hCAFE_F00D);
      hw(12'hF04, GO | dsel(3) | 32'h200);
      @(negedge clk);
      chk("R4", "all-domain request", {29'd0, wake_req}, 32'd7);
      wait_idle(n);
      hw(12'hF04, GO | RD | dsel(2) | 32'h200);
      wait_idle(n);
      rd(12'hF00, v); chk("R5", "all-domain write landed", v, 32'hCAFE_F00D);

      // already awake: minimum busy length
      ack_delay = 2;
      ack_force = 3'b111;
      hw(12'hF04, GO | RD | dsel(3) | 32'h40);
      wait_idle(n);
      chk("R7", "GO cycles when awake", 32'(n), 32'd3);
      rd(12'hF00, v); chk("R6", "read when awake", v, 32'h1111_2222);
      ack_force = 3'b000;

      // host writes during a held command
      ack_auto = 3'b101;
      wake_limit = 16'd50;
      hw(12'hF04, GO | RD | dsel(1) | 32'h40);
      hw(12'hF00, 32'hBAD0_BAD0);
      hw(12'hF04, GO | dsel(0) | 32'h999);
      ack_auto = 3'b111;
      wait_idle(n);
      rd(12'hF00, v); chk("R8", "data write ignored while busy", v, 32'h1111_2222);
      rd(12'hF04, v); chk("R8", "control write ignored while busy", v, 32'h1100_0040);

      // timeout
      ack_auto = 3'b011;
      wake_limit = 16'd5;
      hw(12'hF00, 32'h55AA_55AA);
      e0 = en_count;
      hw(12'hF04, GO | RD | dsel(2) | 32'h80);
      wait_idle(n);
      chk("R9", "GO cycles on abort", 32'(n), 32'd7);
      chk("R9", "no access on abort", 32'(en_count - e0), 32'd0);
      rd(12'hF04, v); chk("R9", "timeout flag", {31'd0, v[30]}, 32'd1);
      rd(12'hF00, v); chk("R9", "data kept on abort", v, 32'h55AA_55AA);

      // sticky flag and clear
      ack_auto = 3'b111;
      wake_limit = 16'd40;
      hw(12'hF04, GO | dsel(0) | 32'h84);
      wait_idle(n);
      rd(12'hF04, v); chk("R10", "flag sticky", {31'd0, v[30]}, 32'd1);
      hw(12'hF04, 32'h4000_0000);
      rd(12'hF04, v); chk("R10", "flag cleared", {31'd0, v[30]}, 32'd0);

      repeat (4) @(posedge clk);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      #1_000_000;
      errors++;
      $display("FAIL R3 watchdog actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule